// File: doc/BRIEF.md
# Prescaled Pulse-Density DAC Modulator

This block turns an 8-bit level into a one-bit stream whose long-run fraction of high steps equals that level divided by 256. An external RC network smooths the stream into an analog voltage, so the block serves as a cheap DAC, for example to drive a gate or set a bias. Inside, an unsigned accumulator adds the level once per modulator step. The carry out of each addition becomes the output bit for the whole of the following step.

A prescaler sets the modulator step rate. It divides the fixed base clock by a programmable 8-bit value. Each output pulse therefore lasts exactly one step. Changing the level changes how often pulses occur, not how wide they are. The pulse rate peaks at midscale and falls symmetrically on either side. Below midscale the stream is short isolated highs. Above midscale it is short isolated lows.

The block runs only from the base clock, so a change in any processor clock has no effect on the output. Level and divider writes are shadowed and reach the datapath only at a step boundary. The accumulator keeps running through such a write.

Top module: `pdm_dac`

## Requirements
- R1: While `enable` is low, `pdm_out` is low one cycle later, the accumulator and prescaler are cleared, and the shadow registers follow `target` and `prescale` every cycle. A run started after at least one disabled cycle begins from accumulator value 0.
- R2: With a divider value P from 1 to 255, a step occurs every P base-clock cycles. The first step falls on the P-th rising edge counted from the first edge that samples `enable` high. `pdm_out` changes only on a step edge or on disable.
- R3: A divider value of 0 behaves as 1, giving a step on every base-clock cycle.
- R4: On each step the unsigned sum of the 8-bit accumulator and the active level is formed as 9 bits. Bit 8 of that sum drives `pdm_out` and bits 7:0 become the new accumulator. Over any 256 consecutive steps at a constant level T, exactly T steps are high.
- R5: Level 0 keeps `pdm_out` low on every step. Level 255 gives exactly one low step in every 256.
- R6: For levels 1 to 128, no two consecutive steps are high. For levels 128 to 255, no two consecutive steps are low after the first step of a run.
- R7: Over 256 steps from a fresh start, levels T and 256−T produce the same number of low-to-high transitions. For example, 64 and 192 each produce 64.
- R8: A new `target` value written between steps is latched on the next step edge and used from the step after that. The accumulator is not cleared by the write.
- R9: A new `prescale` value written between steps is latched on the next step edge and sets the length of the interval that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the modulator when high; clears it when low |
| target | input | 8 | Output level, 0 to 255 |
| prescale | input | 8 | Base-clock cycles per step; 0 behaves as 1 |
| pdm_out | output | 1 | One-bit modulated stream |

## Verification
The bench runs the modulator at levels chosen randomly from a fixed seed, with small dividers, and compares every step against an accumulator model. This separates wrong carry arithmetic from wrong step timing. Directed levels 0, 1, 127, 128, 129 and 255 check the exact 256-step high count and the one-step pulse or gap width at the extremes and around midscale. The pairs 64/192, 32/224 and 1/255 check that the transition counts mirror each other. Writes to the level and divider in the middle of a run, together with disable and restart, show whether the shadowed values wait for the step boundary and whether a new run restarts from zero.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

   localparam int unsigned PDM_LVL_W_DEF = 8;
   localparam int unsigned PDM_DIV_W_DEF = 8;

   typedef enum logic [0:0] {
      PDM_IDLE = 1'b0,
      PDM_RUN  = 1'b1
   } pdm_mode_e;

endpackage

// File: rtl/pdm_step_gen.sv
module pdm_step_gen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             step
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] last;

   // A divider of zero collapses onto one: terminal count 0
   assign last = (div == '0) ? '0 : div - 1'b1;
   assign step = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || step)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= last));

   a_r3_zero_div_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (run && div == '0) |-> step);

   a_r1_idle_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/pdm_shadow.sv
module pdm_shadow #(
   parameter int unsigned LVL_W = 8,
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [LVL_W-1:0] lvl_in,
   input  logic [DIV_W-1:0] div_in,
   output logic [LVL_W-1:0] lvl_act,
   output logic [DIV_W-1:0] div_act
);

   logic load;
   assign load = !run || step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_act <= '0;
         div_act <= '0;
      end else if (load) begin
         lvl_act <= lvl_in;
         div_act <= div_in;
      end
   end

   a_r8_lvl_waits_for_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(lvl_act));

   a_r9_div_waits_for_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(div_act));

endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
   parameter int unsigned LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [LVL_W-1:0] lvl,
   output logic             bit_out
);

   logic [LVL_W-1:0] acc;
   logic [LVL_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         bit_out <= 1'b0;
      end else if (!run) begin
         acc     <= '0;
         bit_out <= 1'b0;
      end else if (step) begin
         acc     <= sum[LVL_W-1:0];
         bit_out <= sum[LVL_W];
      end
   end

   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !bit_out);

   a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(bit_out));

   a_r5_zero_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && lvl == '0) |=> !bit_out);

endmodule

// File: rtl/pdm_dac.sv
module pdm_dac
   import pdm_pkg::*;
#(
   parameter int unsigned LVL_W = PDM_LVL_W_DEF,
   parameter int unsigned DIV_W = PDM_DIV_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [LVL_W-1:0] target,
   input  logic [DIV_W-1:0] prescale,
   output logic             pdm_out
);

   generate
      if (LVL_W < 2 || LVL_W > 16) begin : g_bad_lvl
         $error("pdm_dac: LVL_W must lie in 2..16");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("pdm_dac: DIV_W must lie in 1..16");
      end
   endgenerate

   pdm_mode_e        mode;
   logic             run;
   logic             step;
   logic [LVL_W-1:0] lvl_act;
   logic [DIV_W-1:0] div_act;

   assign mode = enable ? PDM_RUN : PDM_IDLE;
   assign run  = (mode == PDM_RUN);

   pdm_shadow #(.LVL_W(LVL_W), .DIV_W(DIV_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .step    (step),
      .lvl_in  (target),
      .div_in  (prescale),
      .lvl_act (lvl_act),
      .div_act (div_act)
   );

   pdm_step_gen #(.DIV_W(DIV_W)) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (div_act),
      .step  (step)
   );

   pdm_accum #(.LVL_W(LVL_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .step    (step),
      .lvl     (lvl_act),
      .bit_out (pdm_out)
   );

endmodule

// File: tb/pdm_dac_bench.sv
module pdm_dac_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [7:0] target = 8'd0;
   logic [7:0] prescale = 8'd1;
   logic       pdm_out;

   always #4 clk = ~clk;

   pdm_dac u_pdm_dac (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .target   (target),
      .prescale (prescale),
      .pdm_out  (pdm_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int acc_m, t_act, t_pend, p_act, p_pend;
   int highs, rises, hh, ll, idx;
   logic prev_o;

   function automatic int eff_div(input int p);
      return (p == 0) ? 1 : p;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_run(input int t, input int p);
      enable   = 1'b0;
      target   = t[7:0];
      prescale = p[7:0];
      t_pend = t; p_pend = p;
      @(posedge clk); #2;
      @(posedge clk); #2;
      chk(pdm_out == 1'b0, "R1 idle output", int'(pdm_out), 0);
      enable = 1'b1;
      acc_m = 0; t_act = t; p_act = eff_div(p);
      prev_o = 1'b0; highs = 0; rises = 0; hh = 0; ll = 0; idx = 0;
   endtask

   task automatic set_cfg(input int t, input int p);
      target = t[7:0]; prescale = p[7:0];
      t_pend = t; p_pend = p;
   endtask

   task automatic one_step(input string req);
      int s, c;
      repeat (p_act) @(posedge clk);
      #2;
      s = acc_m + t_act;
      c = s >> 8;
      acc_m = s & 255;
      t_act = t_pend;
      p_act = eff_div(p_pend);
      chk(int'(pdm_out) == c, req, int'(pdm_out), c);
      if (pdm_out) highs++;
      if (pdm_out && !prev_o) rises++;
      if (idx > 0 && pdm_out && prev_o) hh++;
      if (idx > 0 && !pdm_out && !prev_o) ll++;
      prev_o = pdm_out;
      idx++;
   endtask

   task automatic density_run(input int t, output int r);
      start_run(t, 1);
      for (int i = 0; i < 256; i++) one_step("R4 step value");
      chk(highs == t, "R4 high count", highs, t);
      if (t >= 1 && t <= 128) chk(hh == 0, "R6 single-step highs", hh, 0);
      if (t >= 128) chk(ll == 0, "R6 single-step lows", ll, 0);
      r = rises;
   endtask

   initial begin
      int r_a, r_b, t, p;
      void'($urandom(32'd24681));
      #3;
      chk(pdm_out == 1'b0, "R1 reset output", int'(pdm_out), 0);
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R2 first step timing with P=5, level 128
      start_run(128, 5);
      for (int i = 0; i < 40; i++) one_step("R2 step timing");

      // R3 divider 0 steps every cycle
      start_run(77, 0);
      for (int i = 0; i < 60; i++) one_step("R3 zero divider");

      // R5 extremes
      density_run(0, r_a);
      chk(r_a == 0, "R5 level 0 never rises", r_a, 0);
      density_run(255, r_b);
      chk(256 - highs == 1, "R5 level 255 single low", 256 - highs, 1);

      // R4 / R6 around midscale
      density_run(1, r_a);
      density_run(127, r_a);
      density_run(128, r_a);
      density_run(129, r_a);

      // R7 symmetric pulse rate
      density_run(64, r_a);
      density_run(192, r_b);
      chk(r_a == r_b, "R7 rate 64 vs 192", r_b, r_a);
      chk(r_a == 64, "R7 rate at 64", r_a, 64);
      density_run(32, r_a);
      density_run(224, r_b);
      chk(r_a == r_b, "R7 rate 32 vs 224", r_b, r_a);
      density_run(1, r_a);
      density_run(255, r_b);
      chk(r_a == r_b, "R7 rate 1 vs 255", r_b, r_a);

      // random levels and dividers
      for (int k = 0; k < 6; k++) begin
         t = int'($urandom_range(255, 0));
         p = int'($urandom_range(4, 0));
         density_run(t, r_a);
         start_run(t, p);
         for (int i = 0; i < 120; i++) one_step("R4 random stream");
      end

      // R8 level write mid-run, accumulator kept
      start_run(50, 2);
      for (int i = 0; i < 7; i++) one_step("R8 before write");
      set_cfg(200, 2);
      for (int i = 0; i < 30; i++) one_step("R8 after level write");

      // R9 divider write mid-run
      start_run(90, 3);
      for (int i = 0; i < 5; i++) one_step("R9 before write");
      set_cfg(90, 6);
      for (int i = 0; i < 20; i++) one_step("R9 after divider write");
      set_cfg(90, 0);
      for (int i = 0; i < 20; i++) one_step("R9 to zero divider");

      // R1 disable mid-run then restart from zero
      start_run(255, 1);
      for (int i = 0; i < 9; i++) one_step("R1 pre-disable");
      enable = 1'b0;
      @(posedge clk); #2;
      chk(pdm_out == 1'b0, "R1 disable clears output", int'(pdm_out), 0);
      repeat (10) @(posedge clk);
      #2;
      chk(pdm_out == 1'b0, "R1 stays low while idle", int'(pdm_out), 0);
      start_run(170, 2);
      for (int i = 0; i < 50; i++) one_step("R1 restart from zero");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule